// File: doc/BRIEF.md
# Parallel Port Status Interrupt Controller

This block turns activity on six status lines of a parallel printer port into a single interrupt request. The lines are the data strobe, the acknowledge, the busy, the paper-empty, the select and the error signal. Each line is asynchronous to the system clock, so it first passes through a synchroniser chain. An edge detector then watches the line for the edge that software has chosen.

A 16-bit control register holds three kinds of bit. The upper six bits are sticky pending flags, one for each source. The lower ten bits hold the enables and the edge polarity selects. The strobe and acknowledge sources have no polarity select and always fire on a rising edge. An enabled edge sets its pending flag. Software clears a flag by writing a one to its bit. The interrupt output is registered and is high while any pending flag has its enable set.

Top module: `pport_irq_ctrl`

## Requirements
- R1: After reset the register reads 16'h0000 and `irq_o` is low.
- R2: The pending flags sit in register bits 15 down to 10. Bit 15 is strobe (`line_in[5]`), bit 14 is acknowledge (`line_in[4]`), bit 13 is busy (`line_in[3]`), bit 12 is paper-empty (`line_in[2]`), bit 11 is select (`line_in[1]`) and bit 10 is error (`line_in[0]`).
- R3: A write with a one in a pending bit clears that flag. A write with a zero there leaves the flag as it was.
- R4: Bit 9 enables strobe and bit 8 enables acknowledge. Both sources set their flag only on a rising edge, and a falling edge on them has no effect.
- R5: Each remaining source has an enable bit and a polarity bit: busy has enable 6 and polarity 7, paper-empty has enable 4 and polarity 5, select has enable 2 and polarity 3, and error has enable 0 and polarity 1. A polarity bit of 1 selects the rising edge and 0 selects the falling edge.
- R6: An edge on a source whose enable bit is 0 does not set its pending flag.
- R7: When an enabled edge and a write-one-to-clear of the same flag fall in the same cycle, the flag stays set.
- R8: `irq_o` is a register. It goes high one cycle after any pending flag and its enable are both 1, and goes low one cycle after no such pair remains. Clearing an enable masks that flag without clearing it.
- R9: A level change on `line_in` that is stable before clock edge k shows in the pending flag after edge k+SYNC_STAGES and in `irq_o` after edge k+SYNC_STAGES+1. Both counts are taken from edge k.
- R10: A write stores bits 9:0 as given, and they read back unchanged on `reg_rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| line_in | input | 6 | Raw status lines: strobe, ack, busy, paper-empty, select, error (bit 5 down to 0) |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 16 | Write data: pending clear mask in 15:10, enables and polarities in 9:0 |
| reg_rdata | output | 16 | Register contents: pending flags in 15:10, control bits in 9:0 |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2. This checks that the detection latency follows the parameter and is not fixed at two flops. It also means the directed case that places a clear write on the exact cycle an edge lands has to count an extra stage. A cycle-level reference model driven by random line toggles and random writes covers the mixes of polarity, enable and clear that the directed cases leave out.

// File: rtl/pport_irq_pkg.sv
package pport_irq_pkg;
  localparam int NSRC     = 6;
  localparam int CTRL_W   = 10;
  localparam int DATA_W   = NSRC + CTRL_W;
  localparam int PEND_LSB = CTRL_W;

  // Source order, high to low: strobe, ack, busy, paper-empty, select, error
  function automatic logic [NSRC-1:0] ctrl_enables(input logic [CTRL_W-1:0] c);
    return {c[9], c[8], c[6], c[4], c[2], c[0]};
  endfunction

  // Strobe and ack are fixed to rising edge
  function automatic logic [NSRC-1:0] ctrl_rise_sel(input logic [CTRL_W-1:0] c);
    return {1'b1, 1'b1, c[7], c[5], c[3], c[1]};
  endfunction
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_d [STAGES];
  logic [WIDTH-1:0] stg_q [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
    end
  end

  assign q = stg_q[STAGES-1];

  generate
    if (STAGES > 1) begin : g_chk
      AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        q == $past(stg_q[STAGES-2])); // R9
    end
  endgenerate
endmodule

// File: rtl/pport_edge_det.sv
module pport_edge_det #(
  parameter int NUM = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] lvl,
  input  logic [NUM-1:0] rise_sel,
  output logic [NUM-1:0] hit
);
  logic [NUM-1:0] prev_q;
  logic [NUM-1:0] rise;
  logic [NUM-1:0] fall;

  always_comb begin
    rise = lvl & ~prev_q;
    fall = ~lvl & prev_q;
    hit  = (rise & rise_sel) | (fall & ~rise_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM; gi++) begin : g_chk
      AST_EDGE_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        hit[gi] |-> (lvl[gi] == rise_sel[gi]) && (lvl[gi] != $past(lvl[gi]))); // R5
    end
  endgenerate
endmodule

// File: rtl/pport_icr_reg.sv
module pport_icr_reg
  import pport_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NSRC-1:0]   hit,
  input  logic [NSRC-1:0]   en_vec,
  output logic [NSRC-1:0]   pend,
  output logic [CTRL_W-1:0] ctrl
);
  logic [NSRC-1:0]   pend_q, pend_d, clr_mask, set_mask;
  logic [CTRL_W-1:0] ctrl_q;

  always_comb begin
    clr_mask = we ? wdata[DATA_W-1:PEND_LSB] : '0;
    set_mask = hit & en_vec;
    pend_d   = set_mask | (pend_q & ~clr_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctrl_q <= '0;
    else if (we) ctrl_q <= wdata[CTRL_W-1:0];
  end

  assign pend = pend_q;
  assign ctrl = ctrl_q;

  AST_CLEAR_ONLY_BY_W1: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend_q) & ~pend_q) & ~($past(we) ? $past(wdata[DATA_W-1:PEND_LSB]) : '0)) == '0); // R3
  AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q)) & ~$past(hit & en_vec)) == '0); // R6
  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hit & en_vec) & ~pend_q) == '0); // R7
endmodule

// File: rtl/pport_irq_ctrl.sv
module pport_irq_ctrl
  import pport_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   line_in,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  logic [NSRC-1:0]   lvl_sync, hit, en_vec, rise_sel, pend;
  logic [CTRL_W-1:0] ctrl;
  logic              irq_q, irq_d;

  pport_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_in), .q(lvl_sync)
  );

  pport_edge_det #(.NUM(NSRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_sync), .rise_sel(rise_sel), .hit(hit)
  );

  pport_icr_reg u_reg (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata),
    .hit(hit), .en_vec(en_vec), .pend(pend), .ctrl(ctrl)
  );

  always_comb begin
    en_vec   = ctrl_enables(ctrl);
    rise_sel = ctrl_rise_sel(ctrl);
    irq_d    = |(pend & en_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o     = irq_q;
  assign reg_rdata = {pend, ctrl};

  AST_FIXED_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit[NSRC-1:NSRC-2]) |-> (|(lvl_sync[NSRC-1:NSRC-2] & hit[NSRC-1:NSRC-2]))); // R4
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past((pend & en_vec) == '0) && ((pend & en_vec) == '0)) |-> !irq_o); // R8
endmodule

// File: tb/pport_irq_ctrl_tb.sv
module pport_irq_ctrl_tb;
  localparam int SYNC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  line_in = '0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pport_irq_ctrl #(.SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  function automatic logic [5:0] tb_en(input logic [9:0] c);
    return {c[9], c[8], c[6], c[4], c[2], c[0]};
  endfunction
  function automatic logic [5:0] tb_rise(input logic [9:0] c);
    return {2'b11, c[7], c[5], c[3], c[1]};
  endfunction

  // Reference model of the requirements, cycle by cycle
  logic [5:0] msh [SYNC];
  logic [5:0] m_prev, m_pend;
  logic [9:0] m_ctrl;
  logic       m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC; s++) msh[s] <= '0;
      m_prev <= '0; m_pend <= '0; m_ctrl <= '0; m_irq <= 1'b0;
    end else begin
      logic [5:0] lv, edg;
      lv  = msh[SYNC-1];
      edg = (tb_rise(m_ctrl) & lv & ~m_prev) | (~tb_rise(m_ctrl) & ~lv & m_prev);
      m_pend <= (edg & tb_en(m_ctrl)) | (m_pend & ~(reg_we ? reg_wdata[15:10] : 6'h0));
      if (reg_we) m_ctrl <= reg_wdata[9:0];
      m_irq  <= |(m_pend & tb_en(m_ctrl));
      m_prev <= lv;
      msh[0] <= line_in;
      for (int s = 1; s < SYNC; s++) msh[s] <= msh[s-1];
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 R3 R10 model register", reg_rdata, {m_pend, m_ctrl});
      chk("R8 R9 model irq", {15'h0, irq_o}, {15'h0, m_irq});
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] v);
    reg_we = 1'b1; reg_wdata = v;
    step(1);
    reg_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    step(3);
    chk("R1 reset register", reg_rdata, 16'h0000);
    chk("R1 reset irq", {15'h0, irq_o}, 16'h0);
    @(posedge clk); #2 rst_n = 1'b1;
    step(2);

    wr(16'h03FF);
    chk("R10 control readback", {6'h0, reg_rdata[9:0]}, 16'h03FF);

    // R9 latency: strobe rise
    line_in[5] = 1'b1;
    step(SYNC);
    chk("R9 pending not yet", {15'h0, reg_rdata[15]}, 16'h0);
    step(1);
    chk("R9 R2 strobe pending", {15'h0, reg_rdata[15]}, 16'h1);
    chk("R9 irq not yet", {15'h0, irq_o}, 16'h0);
    step(1);
    chk("R8 irq high", {15'h0, irq_o}, 16'h1);

    wr(16'h83FF);
    step(1);
    chk("R3 w1c strobe", {15'h0, reg_rdata[15]}, 16'h0);
    chk("R8 irq low after clear", {15'h0, irq_o}, 16'h0);

    line_in[4] = 1'b1;
    step(SYNC + 2);
    chk("R2 ack pending", {10'h0, reg_rdata[15:10]}, 16'h0010);
    wr(16'h03FF);
    step(1);
    chk("R3 write zero keeps flag", {15'h0, reg_rdata[14]}, 16'h1);

    line_in[5] = 1'b0;
    step(SYNC + 3);
    chk("R4 strobe fall ignored", {15'h0, reg_rdata[15]}, 16'h0);

    line_in[4] = 1'b0;
    step(SYNC + 3);
    line_in[4] = 1'b1;
    step(SYNC);
    reg_we = 1'b1; reg_wdata = 16'h43FF;
    step(1);
    reg_we = 1'b0;
    chk("R7 edge beats clear", {15'h0, reg_rdata[14]}, 16'h1);

    wr(16'hFF7F);
    line_in[3] = 1'b1;
    step(SYNC + 3);
    chk("R5 busy rise ignored on falling pol", {15'h0, reg_rdata[13]}, 16'h0);
    line_in[3] = 1'b0;
    step(SYNC + 3);
    chk("R5 busy fall sets", {15'h0, reg_rdata[13]}, 16'h1);

    wr(16'hFF7E);
    line_in[0] = 1'b1;
    step(SYNC + 3);
    line_in[0] = 1'b0;
    step(SYNC + 3);
    chk("R6 disabled error", {15'h0, reg_rdata[10]}, 16'h0);
    chk("R8 no irq", {15'h0, irq_o}, 16'h0);

    line_in[1] = 1'b1;
    step(SYNC + 3);
    chk("R5 select rise sets", {15'h0, reg_rdata[11]}, 16'h1);
    chk("R8 irq on select", {15'h0, irq_o}, 16'h1);
    wr(16'h037A);
    step(1);
    chk("R8 masked irq low", {15'h0, irq_o}, 16'h0);
    chk("R8 flag kept when masked", {15'h0, reg_rdata[11]}, 16'h1);

    // Random phase against the model
    for (int i = 0; i < 4000; i++) begin
      for (int b = 0; b < 6; b++) if ($urandom_range(3) == 0) line_in[b] = ~line_in[b];
      if ($urandom_range(7) == 0) begin
        reg_we = 1'b1; reg_wdata = 16'($urandom);
      end else begin
        reg_we = 1'b0;
      end
      step(1);
    end
    reg_we = 1'b0;
    step(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule